// File: doc/BRIEF.md
# Clocked Byte Serial Port with Bus Registers

This block is a byte-wide serial port that a processor reaches through four word registers on a simple bus. Software places a byte in the transmit holding register. The port then shifts that byte out LSB-first on its data output, one bit per bit tick. The bit tick comes from a 2-bit prescaler select multiplied by a 16-bit divisor.

In the clocked (controller-port) variant, the port also drives a shift clock. It captures a byte from its receive input over the same eight ticks, so every transmitted byte returns one received byte.

Status flags report:
- the state of the holding register;
- receive availability;
- receive overrun;
- the level of a data-set-ready input;
- a pending interrupt.

The interrupt line can be raised by three events: the end of a transmission, the end of a reception, or the DSR input going low. Software clears it with a self-clearing acknowledge bit. A reset bit in the control register aborts any transfer in progress and pulses the DTR output.

Top module: `ctl_serial_port`

## Requirements
- R1: After reset, the status register (offset 1) reads 0x0005, which is bit 0 transmit-ready and bit 2 transmit-empty. Offsets 0, 2 and 3 read 0. `ser_txd`, `ser_sck` and `dtr_n` are high, and `irq` is low.
- R2: The register at offset 2 holds mode in bits 15:0 and control in bits 31:16. Mode is written only when `bus_be[1:0]` is non-zero, and control only when `bus_be[3:2]` is non-zero. The divisor lives in bits 31:16 of offset 3 and is written when `bus_be[3:2]` is non-zero. Every field reads back what was written.
- R3: The bit period is P×D clock cycles, where P is 1, 16 or 64 for mode[1:0] = 1, 2 or 3, and D is the divisor. Mode[1:0] = 0 or D = 0 produces no ticks. Ticks run only while the holding register is full or a shift is in progress. The first bit is driven P×D cycles after the data write.
- R4: A write to offset 0 loads bits 7:0 into the holding register and clears status bits 0 and 2. A frame starts on a tick only when control bit 0 (transmit enable) is set; starting a frame sets both bits again.
- R5: A frame sends 8 bits LSB-first on `ser_txd`. In the clocked variant, `ser_sck` is low for the cycle after each bit tick, and `ser_txd` holds the new bit during that cycle.
- R6: When control bit 10 is set, sending the eighth bit sets the interrupt.
- R7: In the clocked variant, the receive shifter samples `ser_rxd` (after a 2-flop synchronizer) on each bit tick, so the first sampled bit ends in bit 0. After 8 bits the byte is latched and status bit 1 (receive-ready) is set. If control bit 11 is set, the interrupt is also set.
- R8: If status bit 1 is still set when a byte completes, the new byte is discarded and status bit 4 (overrun) is set.
- R9: A read of offset 0 returns the latched byte, clears status bit 1 and refills the buffer with 0xFF.
- R10: Writing control with bit 6 set does all of the following:
  - sets status bits 0 and 2;
  - clears status bits 1, 4 and 9;
  - drops `irq`;
  - drives `dtr_n` low for one cycle;
  - aborts both shifts and drives `ser_txd` high.
- R11: Writing control with bit 4 (acknowledge) set clears status bit 9 and `irq`, and bit 4 reads back as 0. `dtr_n` is the inverse of control bit 1.
- R12: While the synchronized `dsr_n` is low, status bit 7 is set. The interrupt is set only on the transition into that state, and only if control bit 12 is set. `dsr_n` high clears status bit 7.
- R13: `irq` always equals status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-period reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects at offset 0) |
| bus_addr | input | 2 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data for the addressed register |
| ser_txd | output | 1 | Serial data out |
| ser_sck | output | 1 | Shift clock, low one cycle per bit |
| ser_rxd | input | 1 | Serial data in |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| irq | output | 1 | Interrupt request |

## Verification
If the bit counter is left in a wrong state, the port shows it quickly. Extra or missing `ser_sck` falls appear within one bit period. A mis-set counter also shows up as a wrong transmit-empty flag on the next status read. If the receive shifter or buffer is corrupted, the next offset-0 read returns a wrong byte within one frame. A stuck or misrouted interrupt flag is visible on `irq` in the cycle after the event or acknowledge. A broken DSR edge tracker either re-raises `irq` while `dsr_n` stays low, or never raises it, within three cycles.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int ST_TXRDY = 0;
    localparam int ST_RXRDY = 1;
    localparam int ST_TXEMP = 2;
    localparam int ST_OVR   = 4;
    localparam int ST_DSR   = 7;
    localparam int ST_IRQ   = 9;

    localparam int CT_TXEN  = 0;
    localparam int CT_DTR   = 1;
    localparam int CT_ACK   = 4;
    localparam int CT_RST   = 6;
    localparam int CT_TXIE  = 10;
    localparam int CT_RXIE  = 11;
    localparam int CT_DSRIE = 12;

    localparam int FRAME_W  = 8;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int REG_W    = 16;

    typedef struct packed {
        logic [REG_W-1:0]   mode;
        logic [REG_W-1:0]   ctrl;
        logic [REG_W-1:0]   baud;
        logic [FRAME_W-1:0] hold;
        logic [FRAME_W-1:0] tx_sh;
        logic [CNT_W-1:0]   tx_cnt;
        logic [FRAME_W-1:0] rx_sh;
        logic [CNT_W-1:0]   rx_cnt;
        logic [FRAME_W-1:0] rx_buf;
        logic               tx_rdy;
        logic               tx_empty;
        logic               rx_rdy;
        logic               ovr;
        logic               dsr;
        logic               irq;
        logic               txd;
        logic               sck;
        logic               dtr_pulse;
    } sio_state_t;

    function automatic logic [REG_W-1:0] pack_status(sio_state_t s);
        logic [REG_W-1:0] w;
        w           = '0;
        w[ST_TXRDY] = s.tx_rdy;
        w[ST_RXRDY] = s.rx_rdy;
        w[ST_TXEMP] = s.tx_empty;
        w[ST_OVR]   = s.ovr;
        w[ST_DSR]   = s.dsr;
        w[ST_IRQ]   = s.irq;
        return w;
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] ff_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= {STAGES{RST_VAL}};
        else        ff_q <= {ff_q[STAGES-2:0], din};
    end

    assign dout = ff_q[STAGES-1];
endmodule

// File: rtl/sio_baud.sv
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int PER_W = DIV_W + 6;

    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        case (sel)
            2'd1:    period = PER_W'(div);
            2'd2:    period = PER_W'(div) << 4;
            2'd3:    period = PER_W'(div) << 6;
            default: period = '0;
        endcase
        tick  = run && (period != '0) && (cnt_q >= period - PER_W'(1));
        cnt_d = (!run || period == '0 || tick) ? '0 : cnt_q + PER_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ctl_serial_port.sv
module ctl_serial_port
    import sio_pkg::*;
#(
    parameter bit CTRL_PORT   = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    output logic [31:0] bus_rdata,
    output logic        ser_txd,
    output logic        ser_sck,
    input  logic        ser_rxd,
    output logic        dtr_n,
    input  logic        dsr_n,
    output logic        irq
);
    sio_state_t st_d, st_q;
    logic       rxd_s, dsr_s, tick, run;
    logic [REG_W-1:0] ctl_w;

    sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rxd_sync (
        .clk(clk), .rst_n(rst_n), .din(ser_rxd), .dout(rxd_s));
    sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_dsr_sync (
        .clk(clk), .rst_n(rst_n), .din(dsr_n), .dout(dsr_s));

    assign run = !st_q.tx_empty || (st_q.tx_cnt != '0);

    sio_baud #(.DIV_W(REG_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sel(st_q.mode[1:0]), .div(st_q.baud), .tick(tick));

    // Order inside one cycle: data read, DSR, bit tick, then register write.
    always_comb begin
        st_d           = st_q;
        st_d.sck       = 1'b1;
        st_d.dtr_pulse = 1'b0;
        ctl_w          = bus_wdata[31:16];

        if (bus_rd && bus_addr == 2'd0) begin
            st_d.rx_rdy = 1'b0;
            st_d.rx_buf = '1;
        end

        if (dsr_s) begin
            st_d.dsr = 1'b0;
        end else if (!st_q.dsr) begin
            st_d.dsr = 1'b1;
            if (st_q.ctrl[CT_DSRIE]) st_d.irq = 1'b1;
        end

        if (tick) begin
            if (st_d.tx_cnt == '0 && st_q.ctrl[CT_TXEN] && !st_q.tx_empty) begin
                st_d.tx_sh    = st_q.hold;
                st_d.tx_cnt   = CNT_W'(FRAME_W);
                st_d.tx_empty = 1'b1;
                st_d.tx_rdy   = 1'b1;
                if (CTRL_PORT) begin
                    st_d.rx_cnt = CNT_W'(FRAME_W);
                    st_d.rx_sh  = '0;
                end
            end
            if (st_d.tx_cnt != '0) begin
                st_d.txd    = st_d.tx_sh[0];
                st_d.tx_sh  = st_d.tx_sh >> 1;
                st_d.tx_cnt = st_d.tx_cnt - CNT_W'(1);
                if (CTRL_PORT) st_d.sck = 1'b0;
                if (st_d.tx_cnt == '0 && st_q.ctrl[CT_TXIE]) st_d.irq = 1'b1;
            end
            if (st_d.rx_cnt != '0) begin
                st_d.rx_sh  = {rxd_s, st_d.rx_sh[FRAME_W-1:1]};
                st_d.rx_cnt = st_d.rx_cnt - CNT_W'(1);
                if (st_d.rx_cnt == '0) begin
                    if (st_d.rx_rdy) begin
                        st_d.ovr = 1'b1;
                    end else begin
                        st_d.rx_buf = st_d.rx_sh;
                        st_d.rx_rdy = 1'b1;
                    end
                    if (st_q.ctrl[CT_RXIE]) st_d.irq = 1'b1;
                end
            end
        end

        if (bus_wr) begin
            case (bus_addr)
                2'd0: begin
                    st_d.hold     = bus_wdata[FRAME_W-1:0];
                    st_d.tx_rdy   = 1'b0;
                    st_d.tx_empty = 1'b0;
                end
                2'd2: begin
                    if (|bus_be[1:0]) st_d.mode = bus_wdata[15:0];
                    if (|bus_be[3:2]) begin
                        if (ctl_w[CT_RST]) begin
                            st_d.tx_empty  = 1'b1;
                            st_d.tx_rdy    = 1'b1;
                            st_d.rx_rdy    = 1'b0;
                            st_d.ovr       = 1'b0;
                            st_d.irq       = 1'b0;
                            st_d.dtr_pulse = 1'b1;
                            st_d.tx_cnt    = '0;
                            st_d.rx_cnt    = '0;
                            st_d.txd       = 1'b1;
                            st_d.sck       = 1'b1;
                        end
                        if (ctl_w[CT_ACK]) begin
                            st_d.irq       = 1'b0;
                            ctl_w[CT_ACK]  = 1'b0;
                        end
                        st_d.ctrl = ctl_w;
                    end
                end
                2'd3: if (|bus_be[3:2]) st_d.baud = bus_wdata[31:16];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.tx_rdy   <= 1'b1;
            st_q.tx_empty <= 1'b1;
            st_q.txd      <= 1'b1;
            st_q.sck      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            2'd0:    bus_rdata = {24'h0, st_q.rx_buf};
            2'd1:    bus_rdata = {16'h0, pack_status(st_q)};
            2'd2:    bus_rdata = {st_q.ctrl, st_q.mode};
            default: bus_rdata = {st_q.baud, 16'h0};
        endcase
    end

    assign ser_txd = st_q.txd;
    assign ser_sck = st_q.sck;
    assign irq     = st_q.irq;
    assign dtr_n   = ~(st_q.ctrl[CT_DTR] | st_q.dtr_pulse);
endmodule

// File: rtl/sio_port_chk.sv
module sio_port_chk
    import sio_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [3:0]  bus_be,
    input logic        ser_txd,
    input logic        ser_sck,
    input logic        dtr_n,
    input logic        dsr_n,
    input logic        irq,
    input sio_state_t  st
);
    a_r4_write_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (!st.tx_empty && !st.tx_rdy));

    a_r5_sck_low_marks_shift: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_sck |-> (($past(st.tx_cnt) == CNT_W'(st.tx_cnt + CNT_W'(1))) ||
                      ($past(st.tx_cnt) == '0 && st.tx_cnt == CNT_W'(FRAME_W - 1))));

    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (st.tx_cnt <= CNT_W'(FRAME_W)) && (st.rx_cnt <= CNT_W'(FRAME_W)));

    a_r8_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.ovr) |-> $past(st.rx_rdy));

    a_r9_read_consumes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd0) |=> (st.rx_buf == 8'hFF || st.rx_rdy));

    a_r10_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && |bus_be[3:2] && bus_wdata[16 + CT_RST])
        |=> (!irq && !dtr_n && ser_txd && st.tx_cnt == '0 && st.rx_cnt == '0 && st.tx_empty));

    a_r11_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2 && |bus_be[3:2] && bus_wdata[16 + CT_ACK])
        |=> (!irq && !st.ctrl[CT_ACK]));

    a_r12_dsr_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st.dsr) |-> !$past(dsr_n, 3));
endmodule

bind ctl_serial_port sio_port_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
    .ser_txd(ser_txd), .ser_sck(ser_sck), .dtr_n(dtr_n), .dsr_n(dsr_n),
    .irq(irq), .st(st_q));

// File: tb/ctl_serial_port_tb_top.sv
module ctl_serial_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        ser_txd, ser_sck, dtr_n, irq;
    logic        ser_rxd = 1'b1, dsr_n = 1'b1;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    ctl_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .ser_txd(ser_txd), .ser_sck(ser_sck),
        .ser_rxd(ser_rxd), .dtr_n(dtr_n), .dsr_n(dsr_n), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_ctl(input logic [15:0] c);
        do_wr(2'd2, {c, 16'h0}, 4'b1100);
    endtask

    task automatic setup(input logic [1:0] sel, input logic [15:0] div, input logic [15:0] c);
        wr_ctl(16'h0040);
        do_wr(2'd2, {16'h0, 14'h0, sel}, 4'b0011);
        do_wr(2'd3, {div, 16'h0}, 4'b1100);
        wr_ctl(c);
    endtask

    task automatic watch(input int n, output int nf);
        logic prev;
        nf = 0; prev = ser_sck;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (prev && !ser_sck) nf++;
            prev = ser_sck;
        end
    endtask

    task automatic do_frame(input logic [7:0] tx, input logic [7:0] rsp, input int per,
                            output int lat, output int nf, output logic [7:0] cap);
        logic prev;
        int   ridx;
        cap = '0; nf = 0; lat = -1; ridx = 0;
        ser_rxd = rsp[0];
        do_wr(2'd0, {24'h0, tx}, 4'b0001);
        prev = ser_sck;
        for (int k = 1; k <= 8 * per + 12; k++) begin
            @(negedge clk);
            if (prev && !ser_sck) begin
                if (nf < 8) cap[nf] = ser_txd;
                if (lat < 0) lat = k;
                nf++;
            end
            if (!prev && ser_sck) begin
                ridx++;
                if (ridx < 8) ser_rxd = rsp[ridx];
            end
            prev = ser_sck;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  cap, rsp;
        int          lat, nf, pre;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 txd", {31'h0, ser_txd}, 32'h1);
        chk("R1 sck", {31'h0, ser_sck}, 32'h1);
        chk("R1 dtr_n", {31'h0, dtr_n}, 32'h1);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        do_rd(2'd1, v); chk("R1 status", v, 32'h0005);
        do_rd(2'd2, v); chk("R1 mode/ctrl", v, 32'h0);
        do_rd(2'd3, v); chk("R1 baud", v, 32'h0);
        do_rd(2'd0, v); chk("R1 data", v, 32'h0);

        // R2 lane-gated writes
        do_wr(2'd2, 32'hABCD_1234, 4'b0011);
        do_rd(2'd2, v); chk("R2 mode only", v, 32'h0000_1234);
        do_wr(2'd2, 32'h0C01_FFFF, 4'b1100);
        do_rd(2'd2, v); chk("R2 ctrl only", v, 32'h0C01_1234);
        do_wr(2'd3, 32'h0010_BEEF, 4'b1100);
        do_rd(2'd3, v); chk("R2 baud", v, 32'h0010_0000);
        do_wr(2'd3, 32'h0020_0000, 4'b0011);
        do_rd(2'd3, v); chk("R2 baud lanes", v, 32'h0010_0000);
        wr_ctl(16'h0C11);
        do_rd(2'd2, v); chk("R11 ack self-clear", v, 32'h0C01_1234);

        // R3 period sweep
        for (int sel = 1; sel <= 3; sel++) begin
            for (int di = 0; di < 4; di++) begin
                int div;
                div = (di == 3) ? 5 : di + 1;
                pre = (sel == 1) ? 1 : (sel == 2) ? 16 : 64;
                setup(2'(sel), 16'(div), 16'h0001);
                do_frame(8'h3C, 8'h00, pre * div, lat, nf, cap);
                chk("R3 first bit latency", lat, pre * div);
                do_rd(2'd1, v); chk("R3 frame done", v & 32'h7, 32'h7);
            end
        end

        // R3 zero settings give no ticks
        setup(2'd0, 16'd8, 16'h0001);
        do_wr(2'd0, 32'h55, 4'b0001);
        watch(300, nf); chk("R3 sel zero no ticks", nf, 0);
        do_rd(2'd1, v); chk("R3 sel zero held", v & 32'h5, 32'h0);
        setup(2'd1, 16'd0, 16'h0001);
        do_wr(2'd0, 32'h55, 4'b0001);
        watch(300, nf); chk("R3 div zero no ticks", nf, 0);

        // R4 transmit enable gating
        setup(2'd1, 16'd8, 16'h0000);
        do_wr(2'd0, 32'h5A, 4'b0001);
        do_rd(2'd1, v); chk("R4 write clears flags", v & 32'h5, 32'h0);
        watch(200, nf); chk("R4 no start while disabled", nf, 0);
        wr_ctl(16'h0001);
        watch(12, nf);
        do_rd(2'd1, v); chk("R4 start sets flags", v & 32'h5, 32'h5);
        watch(80, nf);
        do_rd(2'd0, v);

        // R5 R7 R9 exhaustive byte sweep
        setup(2'd1, 16'd8, 16'h0001);
        for (int i = 0; i < 256; i++) begin
            rsp = 8'(i * 73 + 29);
            do_frame(8'(i), rsp, 8, lat, nf, cap);
            chk("R5 tx bits", {24'h0, cap}, i);
            chk("R5 sck falls", nf, 8);
            chk("R13 irq idle", {31'h0, irq}, 32'h0);
            do_rd(2'd1, v); chk("R7 rx ready", v & 32'h2, 32'h2);
            do_rd(2'd0, v); chk("R7 rx byte", v, {24'h0, rsp});
            do_rd(2'd0, v); chk("R9 refill FF", v, 32'hFF);
            do_rd(2'd1, v); chk("R9 ready cleared", v & 32'h2, 32'h0);
        end

        // R6 transmit interrupt and R11 ack
        setup(2'd1, 16'd8, 16'h0401);
        do_frame(8'hA5, 8'h11, 8, lat, nf, cap);
        chk("R6 tx irq", {31'h0, irq}, 32'h1);
        do_rd(2'd1, v); chk("R13 status irq bit", v & 32'h200, 32'h200);
        do_rd(2'd0, v);
        wr_ctl(16'h0411);
        chk("R11 ack drops irq", {31'h0, irq}, 32'h0);
        do_rd(2'd1, v); chk("R11 ack clears flag", v & 32'h200, 32'h0);

        // R7 receive interrupt
        setup(2'd1, 16'd8, 16'h0801);
        do_frame(8'h0F, 8'hC3, 8, lat, nf, cap);
        chk("R7 rx irq", {31'h0, irq}, 32'h1);
        wr_ctl(16'h0811);
        do_rd(2'd0, v); chk("R7 rx byte irq case", v, 32'hC3);

        // R8 overrun
        setup(2'd1, 16'd8, 16'h0001);
        do_frame(8'h01, 8'h96, 8, lat, nf, cap);
        do_frame(8'h02, 8'h69, 8, lat, nf, cap);
        do_rd(2'd1, v); chk("R8 overrun flag", v & 32'h12, 32'h12);
        do_rd(2'd0, v); chk("R8 first byte kept", v, 32'h96);
        wr_ctl(16'h0040);
        do_rd(2'd1, v); chk("R10 flags after reset", v, 32'h0005);

        // R10 abort mid-frame
        setup(2'd1, 16'd8, 16'h0801);
        do_frame(8'h44, 8'h22, 8, lat, nf, cap);
        ser_rxd = 1'b0;
        do_wr(2'd0, 32'hF0, 4'b0001);
        watch(28, nf);
        wr_ctl(16'h0040);
        chk("R10 dtr pulse low", {31'h0, dtr_n}, 32'h0);
        chk("R10 txd high", {31'h0, ser_txd}, 32'h1);
        chk("R10 irq dropped", {31'h0, irq}, 32'h0);
        do_rd(2'd1, v); chk("R10 status", v, 32'h0005);
        chk("R10 dtr back high", {31'h0, dtr_n}, 32'h1);
        watch(150, nf); chk("R10 shift aborted", nf, 0);

        // R11 DTR level
        wr_ctl(16'h0002); chk("R11 dtr asserted", {31'h0, dtr_n}, 32'h0);
        wr_ctl(16'h0000); chk("R11 dtr released", {31'h0, dtr_n}, 32'h1);

        // R12 DSR
        wr_ctl(16'h1000);
        dsr_n = 1'b0;
        watch(4, nf);
        do_rd(2'd1, v); chk("R12 dsr flag", v & 32'h80, 32'h80);
        chk("R12 dsr irq", {31'h0, irq}, 32'h1);
        wr_ctl(16'h1010);
        watch(10, nf);
        chk("R12 no refire while low", {31'h0, irq}, 32'h0);
        do_rd(2'd1, v); chk("R12 flag held", v & 32'h80, 32'h80);
        dsr_n = 1'b1;
        watch(4, nf);
        do_rd(2'd1, v); chk("R12 flag cleared", v & 32'h80, 32'h0);
        wr_ctl(16'h0000);
        dsr_n = 1'b0;
        watch(4, nf);
        do_rd(2'd1, v); chk("R12 flag without enable", v & 32'h80, 32'h80);
        chk("R12 no irq without enable", {31'h0, irq}, 32'h0);
        dsr_n = 1'b1;
        watch(4, nf);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule